// File: doc/BRIEF.md
# Power Controller Startup Fault Sequencer

This block is the control core of a resonant converter controller's supply and protection logic. It takes digitised comparator flags for the supply rail, the bulk voltage, the over-voltage/over-temperature input, the feedback skip level and overload. It drives the high-voltage startup source, the gate driver enable, a soft-start request, the PFC mode output, the remote-pin pulldown and the bias enable of the protection block.

After power-up the startup source charges the supply. When the supply reaches its start level, a blanking period opens, together with a longer remote pulldown window. When blanking ends, the drivers start only if no fault is present. Otherwise the block waits and keeps the rail up by switching the startup source between two supply thresholds.

Faults that occur during normal operation lead to one of three waiting states. A brown-out waits for the bulk voltage to return. An over-voltage/over-temperature fault latches the block off until the supply collapses to its reset level. An overload starts a timed auto-recovery restart. All durations are counted in clock cycles.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, and whenever the block is charging, hv_en_o is 1 and every other output is 0, apart from rem_pd_o while its window is still open. The block stays in this state until vcc_on_i is sampled high.
- R2: When vcc_on_i is sampled high while charging (a supply-ON event), the next cycle starts a blanking window of BLANK_CYC cycles and a remote pulldown window of REM_CYC cycles. rem_pd_o is high for exactly REM_CYC cycles. During blanking, hv_en_o is 0 and pfc_mode_o and prot_bias_o are 1.
- R3: Fault inputs have no effect during blanking. In the cycle after the last blanking cycle, drv_en_o goes high only if bo_ok_i is 1 and ovp_i and skip_i are 0 in that last cycle.
- R4: ss_req_o is high in exactly the first cycle in which drv_en_o is high after each start.
- R5: If a fault is present when blanking ends, the drivers stay off and pfc_mode_o and prot_bias_o stay on, with self-supply regulation. Once bo_ok_i=1, ovp_i=0 and skip_i=0, the block returns to charging (hv_en_o=1) in the next cycle.
- R6: If bo_ok_i falls during run, the next cycle has drv_en_o=0, prot_bias_o=0 and pfc_mode_o=1, with self-supply regulation. ovp_i is ignored in this state. When bo_ok_i returns, the block goes to charging.
- R7: If ovp_i is high during run, the block latches off: drv_en_o, pfc_mode_o and prot_bias_o are 0 and only self-supply regulation drives hv_en_o. The latch is left only when vcc_rst_i is high, and the block then goes to charging.
- R8: If ovld_i is high during run, all outputs go off except self-supply regulation for AREC_CYC cycles. The block then goes to charging.
- R9: After auto-recovery, the next supply-ON event restarts both the blanking window and the remote pulldown window, and then the normal start.
- R10: While waiting (R5 to R8), hv_en_o turns on in the cycle after vcc_low_i is sampled high. It turns off in the cycle after vcc_on_i is sampled high. vcc_on_i wins when both are high.
- R11: vcc_rst_i sends the block to charging from any state. During run, ovp_i outranks ovld_i, which outranks a low bo_ok_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply at start level |
| vcc_rst_i | input | 1 | Supply below reset level |
| vcc_low_i | input | 1 | Supply below self-supply regulation level |
| bo_ok_i | input | 1 | Bulk voltage above brown-out level |
| ovp_i | input | 1 | Over-voltage/over-temperature flag |
| skip_i | input | 1 | Feedback below skip level |
| ovld_i | input | 1 | Overload flag |
| hv_en_o | output | 1 | High-voltage startup source enable |
| drv_en_o | output | 1 | Gate driver enable |
| ss_req_o | output | 1 | Soft-start request, one cycle |
| pfc_mode_o | output | 1 | PFC mode output, keeps bulk divider connected |
| rem_pd_o | output | 1 | Remote-pin pulldown |
| prot_bias_o | output | 1 | Protection block bias enable |

## Verification
The bench raises ovp_i in the first blanking cycles and then clears it. A design that checks faults during blanking would never start. A design that checks only at the start of blanking would miss the cleared state. The bench also counts the remote window and the auto-recovery delay cycle by cycle, so a timer that is off by one shows up as an early or late edge on rem_pd_o or hv_en_o. It raises ovp_i, ovld_i and a bulk drop together to check that the latch wins, and it clears those faults while latched to check that only vcc_rst_i releases the block. It drives vcc_on_i and vcc_low_i together to check the self-supply hysteresis, and it raises ovp_i during a brown-out to check that the unbiased protection block is ignored.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE = 3'd0,
    ST_BLANK  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_RUN    = 3'd3,
    ST_BROWN  = 3'd4,
    ST_LATCH  = 3'd5,
    ST_AREC   = 3'd6
  } seq_state_e;

  function automatic logic is_dss(seq_state_e s);
    return (s == ST_WAIT) || (s == ST_BROWN) || (s == ST_LATCH) || (s == ST_AREC);
  endfunction
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned DUR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned W = $clog2(DUR + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= W'(DUR);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  // last counted cycle
  assign done_o = (cnt_q == W'(1));
endmodule

// File: rtl/pwr_seq_vcc_mgr.sv
module pwr_seq_vcc_mgr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dss_act_i,
  input  logic vcc_on_i,
  input  logic vcc_low_i,
  output logic dss_hv_o
);
  logic hv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hv_q <= 1'b0;
    else if (!dss_act_i) hv_q <= 1'b0;
    else if (vcc_on_i)   hv_q <= 1'b0;
    else if (vcc_low_i)  hv_q <= 1'b1;
  end

  assign dss_hv_o = hv_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_rst_i,
  input  logic       bo_ok_i,
  input  logic       ovp_i,
  input  logic       skip_i,
  input  logic       ovld_i,
  input  logic       blank_done_i,
  input  logic       arec_done_i,
  output logic       blank_start_o,
  output logic       arec_start_o,
  output seq_state_e state_o,
  output logic       ss_req_o
);
  seq_state_e state_q, state_d;
  logic       run_seen_q;
  logic       start_ok;

  assign start_ok = bo_ok_i && !ovp_i && !skip_i;

  always_comb begin
    state_d = state_q;
    if (vcc_rst_i) begin
      state_d = ST_CHARGE;
    end else begin
      unique case (state_q)
        ST_CHARGE: if (vcc_on_i)     state_d = ST_BLANK;
        ST_BLANK:  if (blank_done_i) state_d = start_ok ? ST_RUN : ST_WAIT;
        ST_WAIT:   if (start_ok)     state_d = ST_CHARGE;
        ST_RUN: begin
          if (ovp_i)         state_d = ST_LATCH;
          else if (ovld_i)   state_d = ST_AREC;
          else if (!bo_ok_i) state_d = ST_BROWN;
        end
        ST_BROWN:  if (bo_ok_i)      state_d = ST_CHARGE;
        ST_LATCH:  state_d = ST_LATCH;
        ST_AREC:   if (arec_done_i)  state_d = ST_CHARGE;
        default:   state_d = ST_CHARGE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CHARGE;
      run_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      run_seen_q <= (state_q == ST_RUN);
    end
  end

  assign blank_start_o = (state_q == ST_CHARGE) && (state_d == ST_BLANK);
  assign arec_start_o  = (state_q == ST_RUN) && (state_d == ST_AREC);
  assign state_o       = state_q;
  assign ss_req_o      = (state_q == ST_RUN) && !run_seen_q;
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 8,
  parameter int unsigned REM_CYC   = 12,
  parameter int unsigned AREC_CYC  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_on_i,
  input  logic vcc_rst_i,
  input  logic vcc_low_i,
  input  logic bo_ok_i,
  input  logic ovp_i,
  input  logic skip_i,
  input  logic ovld_i,
  output logic hv_en_o,
  output logic drv_en_o,
  output logic ss_req_o,
  output logic pfc_mode_o,
  output logic rem_pd_o,
  output logic prot_bias_o
);
  localparam int unsigned NTMR = 3;
  localparam int unsigned TMR_BLANK = 0;
  localparam int unsigned TMR_REM   = 1;
  localparam int unsigned TMR_AREC  = 2;

  seq_state_e      state;
  logic            blank_start, arec_start;
  logic [NTMR-1:0] tmr_start, tmr_busy, tmr_done;
  logic            dss_hv;

  assign tmr_start[TMR_BLANK] = blank_start;
  assign tmr_start[TMR_REM]   = blank_start;
  assign tmr_start[TMR_AREC]  = arec_start;

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      localparam int unsigned DUR = (g == TMR_BLANK) ? BLANK_CYC :
                                    (g == TMR_REM)   ? REM_CYC : AREC_CYC;
      pwr_seq_timer #(.DUR(DUR)) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(tmr_start[g]),
        .busy_o (tmr_busy[g]),
        .done_o (tmr_done[g])
      );
    end
  endgenerate

  pwr_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vcc_on_i     (vcc_on_i),
    .vcc_rst_i    (vcc_rst_i),
    .bo_ok_i      (bo_ok_i),
    .ovp_i        (ovp_i),
    .skip_i       (skip_i),
    .ovld_i       (ovld_i),
    .blank_done_i (tmr_done[TMR_BLANK]),
    .arec_done_i  (tmr_done[TMR_AREC]),
    .blank_start_o(blank_start),
    .arec_start_o (arec_start),
    .state_o      (state),
    .ss_req_o     (ss_req_o)
  );

  pwr_seq_vcc_mgr u_vcc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dss_act_i(is_dss(state)),
    .vcc_on_i (vcc_on_i),
    .vcc_low_i(vcc_low_i),
    .dss_hv_o (dss_hv)
  );

  assign hv_en_o     = (state == ST_CHARGE) || dss_hv;
  assign drv_en_o    = (state == ST_RUN);
  assign pfc_mode_o  = (state == ST_BLANK) || (state == ST_WAIT) ||
                       (state == ST_RUN)   || (state == ST_BROWN);
  assign prot_bias_o = (state == ST_BLANK) || (state == ST_WAIT) || (state == ST_RUN);
  assign rem_pd_o    = tmr_busy[TMR_REM];
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_rst_i,
  input logic       bo_ok_i,
  input logic       ovp_i,
  input logic       skip_i,
  input logic       ovld_i,
  input logic       hv_en_o,
  input logic       drv_en_o,
  input logic       rem_pd_o,
  input logic       prot_bias_o,
  input logic       pfc_mode_o,
  input logic       blank_busy,
  input seq_state_e state
);
  // R2
  rem_with_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rem_pd_o) |-> blank_busy);

  // R3
  no_drv_in_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !blank_busy);

  // R3
  drv_start_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(bo_ok_i && !ovp_i && !skip_i));

  // R6
  brown_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(drv_en_o) && $past(!bo_ok_i && !ovp_i && !ovld_i && !vcc_rst_i))
      |-> (pfc_mode_o && !prot_bias_o));

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LATCH && !vcc_rst_i) |=> (state == ST_LATCH && !drv_en_o));

  // R1
  hv_drv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hv_en_o && drv_en_o));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vcc_rst_i  (vcc_rst_i),
  .bo_ok_i    (bo_ok_i),
  .ovp_i      (ovp_i),
  .skip_i     (skip_i),
  .ovld_i     (ovld_i),
  .hv_en_o    (hv_en_o),
  .drv_en_o   (drv_en_o),
  .rem_pd_o   (rem_pd_o),
  .prot_bias_o(prot_bias_o),
  .pfc_mode_o (pfc_mode_o),
  .blank_busy (tmr_busy[0]),
  .state      (state)
);

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 4;
  localparam int REM   = 6;
  localparam int AREC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_rst = 0, vcc_low = 0, bo_ok = 0, ovp = 0, skip = 0, ovld = 0;
  logic hv, drv, ss, pfc, rem, bias;
  logic [5:0] outv;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int         t;
    logic [5:0] v;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_top #(.BLANK_CYC(BLANK), .REM_CYC(REM), .AREC_CYC(AREC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .vcc_on_i(vcc_on), .vcc_rst_i(vcc_rst), .vcc_low_i(vcc_low),
    .bo_ok_i(bo_ok), .ovp_i(ovp), .skip_i(skip), .ovld_i(ovld),
    .hv_en_o(hv), .drv_en_o(drv), .ss_req_o(ss),
    .pfc_mode_o(pfc), .rem_pd_o(rem), .prot_bias_o(bias)
  );

  // order: hv drv ss pfc rem bias
  assign outv = {hv, drv, ss, pfc, rem, bias};

  // monitor
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].t == cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (outv !== it.v) begin
        fails++;
        $display("FAIL %s cycle %0d actual=%b expected=%b", it.req, cyc, outv, it.v);
      end
    end
  end

  // driver: expectation for outputs after the coming edge
  task automatic step(input logic [5:0] v, input string r);
    sb_q.push_back('{cyc + 1, v, r});
    @(negedge clk);
  endtask

  task automatic steps(input int n, input logic [5:0] v, input string r);
    for (int i = 0; i < n; i++) step(v, r);
  endtask

  // blank then start, full sequence from supply-ON
  task automatic clean_start(input string r);
    vcc_on = 1;
    steps(BLANK, 6'b000111, r);
    step(6'b011111, "R3");
    step(6'b010111, "R4");
    step(6'b010101, "R2");
  endtask

  initial begin
    #(CLK_PERIOD*3000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    steps(2, 6'b100000, "R1");

    // faults during blanking ignored
    vcc_on = 1; bo_ok = 1; ovp = 1;
    steps(2, 6'b000111, "R3");
    ovp = 0;
    steps(2, 6'b000111, "R2");
    step(6'b011111, "R3");
    step(6'b010111, "R4");
    step(6'b010101, "R2");

    // overload and auto-recovery with self-supply hysteresis
    ovld = 1;
    step(6'b000000, "R8");
    ovld = 0; vcc_on = 0; vcc_low = 1;
    step(6'b100000, "R10");
    vcc_low = 0;
    step(6'b100000, "R10");
    vcc_on = 1; vcc_low = 1;
    step(6'b000000, "R10");
    vcc_on = 0; vcc_low = 0;
    steps(AREC - 4, 6'b000000, "R8");
    step(6'b100000, "R8");
    clean_start("R9");
    step(6'b010101, "R9");

    // brown-out, ovp ignored while unbiased
    bo_ok = 0; vcc_on = 0;
    step(6'b000100, "R6");
    vcc_low = 1; ovp = 1;
    steps(2, 6'b100100, "R6");
    vcc_low = 0; ovp = 0; bo_ok = 1;
    step(6'b100000, "R6");
    clean_start("R2");

    // priority: latch wins, only reset releases
    ovp = 1; ovld = 1; bo_ok = 0; vcc_on = 0;
    step(6'b000000, "R11");
    vcc_low = 1;
    step(6'b100000, "R7");
    vcc_low = 0; vcc_on = 1;
    step(6'b000000, "R7");
    ovp = 0; ovld = 0; bo_ok = 1;
    steps(3, 6'b000000, "R7");
    vcc_rst = 1; vcc_on = 0;
    step(6'b100000, "R7");
    vcc_rst = 0;
    step(6'b100000, "R1");

    // fault at blank end -> wait
    vcc_on = 1; skip = 1;
    steps(BLANK, 6'b000111, "R2");
    steps(2, 6'b000111, "R5");
    step(6'b000101, "R5");
    vcc_on = 0; vcc_low = 1;
    step(6'b100101, "R5");
    skip = 0; vcc_low = 0;
    step(6'b100000, "R5");
    clean_start("R3");

    // supply reset outranks latch entry
    vcc_rst = 1; ovp = 1; vcc_on = 0;
    step(6'b100000, "R11");
    vcc_rst = 0; ovp = 0;
    step(6'b100000, "R11");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule